// File: doc/BRIEF.md
# Dual-Pixel Raster Timing Generator

This block produces the raster timing and a colour-bar image for a 1920x1080, 60 Hz video stream whose pixel rate is 148.5 MHz. Its core logic runs at half that rate, 74.25 MHz. Each core cycle covers two horizontally adjacent pixels: the left pixel has an even x coordinate and the right pixel has an odd one. The horizontal position counter therefore counts pixel pairs. All horizontal events are decoded at pair boundaries, and every horizontal interval has an even length.

In each core cycle the block computes sync, data-enable and the colours of both pixels of the current pair. A small output stage then places the pair onto a single-pixel parallel RGB bus. This stage is clocked by a phase-aligned clock at twice the core rate. The left pixel occupies the first half of the core period and the right pixel the second half. Sync and enable are repeated in both halves.

The bus is meant to feed an external parallel-RGB-to-serial transmitter. Clock synthesis happens outside the block. All timing numbers are parameters. The defaults give the 1080p raster, and a smaller raster can be chosen for simulation.

Top module: `pair_raster_gen`

## Requirements
- R1: The pair counter advances by one pair (two pixels) per core clock and wraps after H_TOT/2 pairs, so every line lasts exactly H_TOT = 2200 pixel periods by default.
- R2: The line counter advances by one when the pair counter wraps and returns to 0 after V_TOT = 1125 lines, so a frame lasts H_TOT*V_TOT pixel periods.
- R3: With x = 0 as the first active pixel of a line, `vid_hs` is high (active high) exactly for x from H_ACT+H_FP up to H_ACT+H_FP+H_SYNC-1, which is 2008 to 2051 by default.
- R4: With y = 0 as the first active line, `vid_vs` is high (active high) for every pixel of lines V_ACT+V_FP up to V_ACT+V_FP+V_SYNC-1, which is 1084 to 1088 by default.
- R5: `vid_de` is high exactly when x < H_ACT and y < V_ACT, giving H_ACT*V_ACT enabled pixels per frame. It is never high together with either sync.
- R6: The even pixel of a pair is driven during the first half of the core period and the odd pixel during the second half. `vid_hs`, `vid_vs` and `vid_de` hold the same value in both halves.
- R7: In the active area the colour comes from bar index b = x / (H_ACT/8), computed separately for each pixel, so a pair may straddle two bars. `vid_rgb` is {R, G, B}, each CW bits wide and all ones or all zeros, with R = not b[1], G = not b[2] and B = not b[0]: white, yellow, cyan, green, magenta, red, blue, black. Outside the active area `vid_rgb` is 0.
- R8: `rst` is synchronous to the core clock. While it is held, the counters sit at x = 0, y = 0 and the outputs are blank (all zero). After release, pixel (0,0) appears in the first half of the second core cycle that follows the first core edge with `rst` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_core | input | 1 | Core clock, half the pixel rate |
| clk_pix | input | 1 | Pixel clock, twice the core rate, rising edges aligned to core rising edges |
| rst | input | 1 | Synchronous reset, active high, core domain |
| vid_rgb | output | 3*CW | Serialized pixel colour {R, G, B} |
| vid_hs | output | 1 | Horizontal sync, active high |
| vid_vs | output | 1 | Vertical sync, active high |
| vid_de | output | 1 | Data enable, active high |

## Verification
The bench uses a reduced raster whose bar width is odd, so that some pairs straddle a bar boundary. At those pairs a design that swapped the two pixels, or that coloured both pixels from the even coordinate, shows the wrong colour on one half-period. Sync edges are compared pixel by pixel. A decode that is off by one pair would move a horizontal sync edge by two pixels, and a wrong wrap value would change the spacing between sync pulses and the number of enabled pixels per frame. Reset is applied again in the middle of a frame. A design that failed to clear its counters would resume at a non-zero position instead of pixel (0,0).

// File: rtl/pair_raster_gen.sv
module pair_raster_gen #(
  parameter int H_ACT  = 1920,
  parameter int H_FP   = 88,
  parameter int H_SYNC = 44,
  parameter int H_BP   = 148,
  parameter int V_ACT  = 1080,
  parameter int V_FP   = 4,
  parameter int V_SYNC = 5,
  parameter int V_BP   = 36,
  parameter int CW     = 8
) (
  input  logic            clk_core,
  input  logic            clk_pix,
  input  logic            rst,
  output logic [3*CW-1:0] vid_rgb,
  output logic            vid_hs,
  output logic            vid_vs,
  output logic            vid_de
);

  localparam int HP_TOT = (H_ACT + H_FP + H_SYNC + H_BP) / 2;
  localparam int V_TOT  = V_ACT + V_FP + V_SYNC + V_BP;
  localparam int HW     = $clog2(HP_TOT);
  localparam int VW     = $clog2(V_TOT);
  localparam int BAR_W  = H_ACT / 8;
  localparam int BW     = $clog2(BAR_W + 2);

  localparam logic [HW-1:0] HP_LAST = HW'(HP_TOT - 1);
  localparam logic [HW-1:0] HP_ACT  = HW'(H_ACT / 2);
  localparam logic [HW-1:0] HP_SS   = HW'((H_ACT + H_FP) / 2);
  localparam logic [HW-1:0] HP_SE   = HW'((H_ACT + H_FP + H_SYNC) / 2);
  localparam logic [VW-1:0] V_LAST  = VW'(V_TOT - 1);
  localparam logic [VW-1:0] V_ACTL  = VW'(V_ACT);
  localparam logic [VW-1:0] V_SS    = VW'(V_ACT + V_FP);
  localparam logic [VW-1:0] V_SE    = VW'(V_ACT + V_FP + V_SYNC);
  localparam logic [BW-1:0] BAR_WL  = BW'(BAR_W);

  logic [HW-1:0]   hp;
  logic [VW-1:0]   vl;
  logic [BW-1:0]   bpos;
  logic [2:0]      bidx;
  logic            de_q, hs_q, vs_q;
  logic [3*CW-1:0] ev_q, od_q, odd_h;
  logic            tgl, tq;

  function automatic logic [3*CW-1:0] bar_rgb(input logic [2:0] i);
    return {{CW{~i[1]}}, {CW{~i[2]}}, {CW{~i[0]}}};
  endfunction

  wire            h_end  = (hp == HP_LAST);
  wire            v_end  = (vl == V_LAST);
  wire            act    = (hp < HP_ACT) && (vl < V_ACTL);
  wire [BW-1:0]   bstep  = bpos + BW'(2);
  wire [2:0]      bidx_o = (bpos + BW'(1) == BAR_WL) ? bidx + 3'd1 : bidx;
  wire            half0  = (tgl == tq);

  always_ff @(posedge clk_core) begin
    if (rst) begin
      hp   <= '0;
      vl   <= '0;
      bpos <= '0;
      bidx <= '0;
      tgl  <= 1'b0;
      de_q <= 1'b0;
      hs_q <= 1'b0;
      vs_q <= 1'b0;
      ev_q <= '0;
      od_q <= '0;
    end else begin
      tgl <= ~tgl;
      hp  <= h_end ? '0 : hp + HW'(1);
      if (h_end) vl <= v_end ? '0 : vl + VW'(1);
      if (h_end) begin
        bpos <= '0;
        bidx <= '0;
      end else if (bstep >= BAR_WL) begin
        bpos <= bstep - BAR_WL;
        bidx <= bidx + 3'd1;
      end else begin
        bpos <= bstep;
      end
      de_q <= act;
      hs_q <= (hp >= HP_SS) && (hp < HP_SE);
      vs_q <= (vl >= V_SS) && (vl < V_SE);
      ev_q <= act ? bar_rgb(bidx) : '0;
      od_q <= act ? bar_rgb(bidx_o) : '0;
    end
  end

  always_ff @(posedge clk_pix) begin
    tq <= tgl;
    if (half0) begin
      vid_rgb <= ev_q;
      odd_h   <= od_q;
      vid_hs  <= hs_q;
      vid_vs  <= vs_q;
      vid_de  <= de_q;
    end else begin
      vid_rgb <= odd_h;
    end
  end

endmodule

// File: rtl/pair_raster_gen_chk.sv
module pair_raster_gen_chk #(
  parameter int HW     = 11,
  parameter int VW     = 11,
  parameter int HP_TOT = 1100,
  parameter int V_TOT  = 1125
) (
  input logic          clk_core,
  input logic          clk_pix,
  input logic          rst,
  input logic [HW-1:0] hp,
  input logic [VW-1:0] vl,
  input logic          vs_q,
  input logic          de_q,
  input logic          half0,
  input logic          vid_hs,
  input logic          vid_vs,
  input logic          vid_de
);

  localparam logic [HW-1:0] HLAST = HW'(HP_TOT - 1);
  localparam logic [VW-1:0] VLAST = VW'(V_TOT - 1);

  logic rst_d = 1'b0;

  p_pair_step_r1: assert property (@(posedge clk_core) disable iff (rst)
    (hp != HLAST) |=> (hp == $past(hp) + HW'(1)));

  p_pair_wrap_r1: assert property (@(posedge clk_core) disable iff (rst)
    (hp == HLAST) |=> (hp == '0));

  p_line_step_r2: assert property (@(posedge clk_core) disable iff (rst)
    (hp == HLAST && vl != VLAST) |=> (vl == $past(vl) + VW'(1)));

  p_line_hold_r2: assert property (@(posedge clk_core) disable iff (rst)
    (hp != HLAST) |=> $stable(vl));

  p_vs_line_r4: assert property (@(posedge clk_core) disable iff (rst)
    (hp != HW'(1)) |-> $stable(vs_q));

  p_blank_excl_r5: assert property (@(posedge clk_pix) disable iff (rst)
    vid_de |-> (!vid_hs && !vid_vs));

  p_ctrl_hold_r6: assert property (@(posedge clk_pix) disable iff (rst)
    !half0 |=> ($stable(vid_hs) && $stable(vid_vs) && $stable(vid_de)));

  always_ff @(posedge clk_core) begin
    rst_d <= rst;
    if (rst_d) p_reset_state_r8: assert (hp == '0 && vl == '0 && !de_q);
  end

endmodule

bind pair_raster_gen pair_raster_gen_chk #(
  .HW(HW), .VW(VW), .HP_TOT(HP_TOT), .V_TOT(V_TOT)
) u_chk (
  .clk_core(clk_core), .clk_pix(clk_pix), .rst(rst),
  .hp(hp), .vl(vl), .vs_q(vs_q), .de_q(de_q), .half0(half0),
  .vid_hs(vid_hs), .vid_vs(vid_vs), .vid_de(vid_de)
);

// File: tb/test_pair_raster_gen.sv
module test_pair_raster_gen;
  localparam int HA = 40, HF = 4, HS = 6, HB = 10;
  localparam int VA = 6,  VF = 2, VS = 3, VB = 4;
  localparam int HT = HA + HF + HS + HB;
  localparam int VT = VA + VF + VS + VB;
  localparam int FR = HT * VT;
  localparam int BARW = HA / 8;

  typedef struct packed {
    logic [23:0] rgb;
    logic hs, vs, de;
  } pix_t;

  logic clk_core, clk_pix, rst;
  logic [23:0] vid_rgb;
  logic vid_hs, vid_vs, vid_de;

  pix_t sb[$];
  int   compared = 0, mismatched = 0;
  bit   mon_on = 0;
  int   idx, de_cnt, hs_rises, vs_rises, last_hs, last_vs;
  logic prev_hs, prev_vs;

  pair_raster_gen #(
    .H_ACT(HA), .H_FP(HF), .H_SYNC(HS), .H_BP(HB),
    .V_ACT(VA), .V_FP(VF), .V_SYNC(VS), .V_BP(VB), .CW(8)
  ) i_pair_raster_gen (
    .clk_core(clk_core), .clk_pix(clk_pix), .rst(rst),
    .vid_rgb(vid_rgb), .vid_hs(vid_hs), .vid_vs(vid_vs), .vid_de(vid_de)
  );

  initial begin
    clk_pix = 0;
    clk_core = 0;
    forever begin
      #4 clk_pix = 1; clk_core = ~clk_core;
      #4 clk_pix = 0;
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  task automatic check(input bit ok, input string msg, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", msg, act, exp);
    end
  endtask

  task automatic push_pixels(input int n);
    for (int k = 0; k < n; k++) begin
      pix_t p;
      int x, y, b;
      x = k % HT;
      y = (k / HT) % VT;
      b = x / BARW;
      p.de = (x < HA) && (y < VA);
      p.hs = (x >= HA + HF) && (x < HA + HF + HS);
      p.vs = (y >= VA + VF) && (y < VA + VF + VS);
      p.rgb = p.de ? {{8{~b[1]}}, {8{~b[2]}}, {8{~b[0]}}} : 24'h0;
      sb.push_back(p);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk_pix);
      if (mon_on && sb.size() > 0) begin
        pix_t e;
        e = sb.pop_front();
        compared++;
        if (vid_rgb !== e.rgb || vid_hs !== e.hs || vid_vs !== e.vs || vid_de !== e.de) begin
          mismatched++;
          if (mismatched < 20) begin
            if (vid_rgb !== e.rgb)
              $display("FAIL R6/R7 pixel %0d rgb: actual %h expected %h", idx, vid_rgb, e.rgb);
            if (vid_hs !== e.hs)
              $display("FAIL R3 pixel %0d hs: actual %0b expected %0b", idx, vid_hs, e.hs);
            if (vid_vs !== e.vs)
              $display("FAIL R4 pixel %0d vs: actual %0b expected %0b", idx, vid_vs, e.vs);
            if (vid_de !== e.de)
              $display("FAIL R5 pixel %0d de: actual %0b expected %0b", idx, vid_de, e.de);
          end
        end
        if (vid_de) de_cnt++;
        if (vid_hs && !prev_hs) begin
          if (last_hs >= 0) check(idx - last_hs == HT, "R1 hsync spacing", idx - last_hs, HT);
          last_hs = idx;
          hs_rises++;
        end
        if (vid_vs && !prev_vs) begin
          if (last_vs >= 0) check(idx - last_vs == FR, "R2 vsync spacing", idx - last_vs, FR);
          last_vs = idx;
          vs_rises++;
        end
        prev_hs = vid_hs;
        prev_vs = vid_vs;
        idx++;
      end
    end
  end

  task automatic chk_blank(input string tag);
    check(vid_de == 0 && vid_hs == 0 && vid_vs == 0 && vid_rgb == 0, tag,
          int'({vid_de, vid_hs, vid_vs, |vid_rgb}), 0);
  endtask

  task automatic run_frames(input int nf);
    sb.delete();
    push_pixels(nf * FR);
    idx = 0; de_cnt = 0; hs_rises = 0; vs_rises = 0;
    last_hs = -1; last_vs = -1; prev_hs = 0; prev_vs = 0;
    @(posedge clk_core);
    #2 rst = 0;
    @(posedge clk_core);
    @(posedge clk_core);
    mon_on = 1;
    while (sb.size() != 0) @(negedge clk_pix);
    #1 mon_on = 0;
    check(de_cnt == nf * HA * VA, "R5 enabled pixel count", de_cnt, nf * HA * VA);
    check(hs_rises == nf * VT, "R3 hsync pulses", hs_rises, nf * VT);
    check(vs_rises == nf, "R4 vsync pulses", vs_rises, nf);
  endtask

  initial begin
    rst = 1;
    repeat (5) @(posedge clk_core);
    @(negedge clk_pix);
    chk_blank("R8 blank in reset");
    run_frames(2);
    repeat (37) @(posedge clk_core);
    #2 rst = 1;
    repeat (3) @(posedge clk_core);
    @(negedge clk_pix);
    chk_blank("R8 blank after mid-frame reset");
    run_frames(1);
    summary();
    $finish;
  end

  initial begin
    #500000;
    mismatched++;
    compared++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end
endmodule